// File: doc/BRIEF.md
# Tamper Input Glitch Filter

This block watches four tamper sources and records each one in a sticky status bit. Three of the sources are external pins. Each of these passes through a two-flop synchronizer and then a digital glitch filter. The fourth source is an internal signal that is already synchronous, and it sets its status bit directly with no filtering.

Each external channel has three settings: a polarity bit, a 3-bit selector, and a duration count. The selector picks one of eight sample-tick inputs. These ticks come from a timebase that runs from the fastest rate (32 kHz) down to the slowest (2 Hz). A pin is treated as tampered only when its active level has been seen on enough consecutive selected ticks.

Software loads the settings through a small write port. It can then set a freeze latch, and after that the filter settings cannot change until reset. The status bits clear only through a write-one-to-clear input. The interrupt is the OR of all status bits, gated by an enable. All interfaces are plain control and status pins. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `tampf_top`

## Requirements
- R1: After reset all status bits are 0. The interrupt is 0 even when irq_en is 1.
- R2: A pin level applied before clock edge k is first seen by a tick that is sampled at edge k+2, because of the two-flop synchronizer. The status changes at that edge.
- R3: Only the tick line whose index equals the channel's rate code advances that channel's filter. The codes are: 0=32 kHz, 1=512 Hz, 2=128 Hz, 3=64 Hz, 4=16 Hz, 5=8 Hz, 6=4 Hz, 7=2 Hz. Pulses on the other tick lines have no effect on the status.
- R4: For a duration D of 1 or more, the status bit of channel i (bit i) sets on the D-th consecutive active selected tick, and not before.
- R5: A duration of 0 acts like 1: the first active selected tick sets the status.
- R6: A selected tick that sees the inactive level clears the filter count. The run then has to start again from zero.
- R7: With polarity 0 the active level is high. With polarity 1 the active level is low. Ticks that see the inactive level never set the status.
- R8: The internal source (int_src) sets status bit 3 at the first clock edge where it is high, with no synchronizer and no filter.
- R9: Status bits stay set until a 1 is written to the matching sts_clr bit. If a set and a clear happen in the same cycle, the set wins.
- R10: irq is 1 exactly when irq_en is 1 and at least one status bit is set. It follows in the same cycle.
- R11: After cfg_lock is pulsed, writes to the filter settings are ignored until reset. The filters keep working with the settings they held before the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one channel's settings |
| cfg_chan | input | 2 | Channel index for the write (0 to 2) |
| cfg_pol | input | 1 | Polarity: 1 means active-low |
| cfg_rate | input | 3 | Sample tick selector |
| cfg_dur | input | 4 | Duration in sample ticks |
| cfg_lock | input | 1 | Pulse that freezes the settings until reset |
| irq_en | input | 1 | Interrupt enable |
| sts_clr | input | 4 | Write-one-to-clear strobe per status bit |
| tick | input | 8 | Single-cycle sample tick pulses, one line per rate code |
| pin | input | 3 | Raw, asynchronous external tamper pins |
| int_src | input | 1 | Internal tamper source, synchronous, active high |
| sts | output | 4 | Sticky status: bits 0 to 2 are the pins, bit 3 is the internal source |
| irq | output | 1 | Tamper interrupt |

## Verification
A pin level is first visible to a tick sampled two edges after it is applied. The status bit registers at the edge where the qualifying tick is sampled. The internal source and the clear input each act at the next edge, and irq follows the status in the same cycle.

The bench changes inputs on falling edges and holds each tick for exactly one rising edge. It reads sts at the next falling edge. It waits three cycles after every pin change before it pulses a tick, except in the latency test, which samples on each edge to find the exact two-edge delay.

The main sweep covers every channel, both polarities, all eight rates and durations 0 to 4. For each case the bench computes the tick count that should set the status, and checks the status after each tick.

// File: rtl/tampf_pkg.sv
package tampf_pkg;
  localparam int TF_EXT_CH = 3;
  localparam int TF_RATES  = 8;
  localparam int TF_DUR_W  = 4;

  // Sample tick selector codes (index into the tick vector)
  typedef enum logic [2:0] {
    RATE_32K = 3'd0,
    RATE_512 = 3'd1,
    RATE_128 = 3'd2,
    RATE_64  = 3'd3,
    RATE_16  = 3'd4,
    RATE_8   = 3'd5,
    RATE_4   = 3'd6,
    RATE_2   = 3'd7
  } rate_e;
endpackage

// File: rtl/tampf_sync.sv
module tampf_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/tampf_cfg.sv
module tampf_cfg #(
  parameter int NUM_EXT = 3,
  parameter int DUR_W   = 4,
  parameter int SEL_W   = 3,
  parameter int CH_W    = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [CH_W-1:0]                 chan,
  input  logic                            pol_in,
  input  logic [SEL_W-1:0]                rate_in,
  input  logic [DUR_W-1:0]                dur_in,
  input  logic                            lock_req,
  output logic [NUM_EXT-1:0]              pol_q,
  output logic [NUM_EXT-1:0][SEL_W-1:0]   rate_q,
  output logic [NUM_EXT-1:0][DUR_W-1:0]   dur_q
);
  logic frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frozen <= 1'b0;
    else if (lock_req) frozen <= 1'b1;
  end

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol_q[g]  <= 1'b0;
        rate_q[g] <= '0;
        dur_q[g]  <= '0;
      end else if (we && !frozen && chan == CH_W'(g)) begin
        pol_q[g]  <= pol_in;
        rate_q[g] <= rate_in;
        dur_q[g]  <= dur_in;
      end
    end
  end

  // Once frozen, settings never move again until reset
  assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(pol_q) && $stable(rate_q) && $stable(dur_q)));
endmodule

// File: rtl/tampf_filt.sv
module tampf_filt #(
  parameter int DUR_W  = 4,
  parameter int SEL_W  = 3,
  parameter int RATE_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  logic              pol,
  input  logic [SEL_W-1:0]  rate,
  input  logic [DUR_W-1:0]  dur,
  input  logic [RATE_N-1:0] tick,
  output logic              hit
);
  logic             active;
  logic             smp;
  logic [DUR_W-1:0] cnt;
  logic [DUR_W:0]   need;
  logic [DUR_W:0]   cnt_p1;

  always_comb begin
    active = lvl ^ pol;
    smp    = tick[rate];
    need   = (dur == '0) ? (DUR_W+1)'(1) : {1'b0, dur};
    cnt_p1 = {1'b0, cnt} + (DUR_W+1)'(1);
    hit    = smp && active && (cnt_p1 >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (smp) begin
      if (!active)  cnt <= '0;
      else if (!hit) cnt <= cnt_p1[DUR_W-1:0];
    end
  end

  assert_idle_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && !active) |=> (cnt == '0));
endmodule

// File: rtl/tampf_top.sv
module tampf_top #(
  parameter int NUM_EXT = tampf_pkg::TF_EXT_CH,
  parameter int RATE_N  = tampf_pkg::TF_RATES,
  parameter int DUR_W   = tampf_pkg::TF_DUR_W,
  localparam int NCH    = NUM_EXT + 1,
  localparam int SEL_W  = $clog2(RATE_N),
  localparam int CH_W   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_pol,
  input  logic [SEL_W-1:0]  cfg_rate,
  input  logic [DUR_W-1:0]  cfg_dur,
  input  logic              cfg_lock,
  input  logic              irq_en,
  input  logic [NCH-1:0]    sts_clr,
  input  logic [RATE_N-1:0] tick,
  input  logic [NUM_EXT-1:0] pin,
  input  logic              int_src,
  output logic [NCH-1:0]    sts,
  output logic              irq
);
  logic [NUM_EXT-1:0]            pin_s;
  logic [NUM_EXT-1:0]            pol_q;
  logic [NUM_EXT-1:0][SEL_W-1:0] rate_q;
  logic [NUM_EXT-1:0][DUR_W-1:0] dur_q;
  logic [NUM_EXT-1:0]            hit;
  logic [NCH-1:0]                set_v;

  tampf_sync #(.W(NUM_EXT)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
  );

  tampf_cfg #(.NUM_EXT(NUM_EXT), .DUR_W(DUR_W), .SEL_W(SEL_W), .CH_W(CH_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .chan(cfg_chan),
    .pol_in(cfg_pol), .rate_in(cfg_rate), .dur_in(cfg_dur),
    .lock_req(cfg_lock), .pol_q(pol_q), .rate_q(rate_q), .dur_q(dur_q)
  );

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ch
    tampf_filt #(.DUR_W(DUR_W), .SEL_W(SEL_W), .RATE_N(RATE_N)) i_filt (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s[g]), .pol(pol_q[g]),
      .rate(rate_q[g]), .dur(dur_q[g]), .tick(tick), .hit(hit[g])
    );
  end

  assign set_v = {int_src, hit};

  // Sticky status: a new event in the same cycle beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~sts_clr) | set_v;
  end

  assign irq = irq_en && (|sts);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(sts) & ~$past(sts_clr)) == ($past(sts) & ~$past(sts_clr))));
  assert_hit_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((sts[NUM_EXT-1:0] & $past(hit)) == $past(hit)));
  assert_internal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_src |=> sts[NUM_EXT]);
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
endmodule

// File: tb/test_tampf_top.sv
module test_tampf_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_chan = '0;
  logic       cfg_pol = 1'b0;
  logic [2:0] cfg_rate = '0;
  logic [3:0] cfg_dur = '0;
  logic       cfg_lock = 1'b0;
  logic       irq_en = 1'b0;
  logic [3:0] sts_clr = '0;
  logic [7:0] tick = '0;
  logic [2:0] pin = '0;
  logic       int_src = 1'b0;
  logic [3:0] sts;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tampf_top i_tampf_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_pol(cfg_pol), .cfg_rate(cfg_rate), .cfg_dur(cfg_dur),
    .cfg_lock(cfg_lock), .irq_en(irq_en), .sts_clr(sts_clr), .tick(tick),
    .pin(pin), .int_src(int_src), .sts(sts), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick = '0; sts_clr = '0; int_src = 1'b0; cfg_we = 1'b0; cfg_lock = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic wcfg(input int ch, input bit pl, input int rt, input int du);
    cfg_chan = 2'(ch); cfg_pol = pl; cfg_rate = 3'(rt); cfg_dur = 4'(du);
    cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int r);
    tick = '0;
    tick[r] = 1'b1;
    step(1);
    tick = '0;
  endtask

  initial begin
    step(1);
    do_reset();
    irq_en = 1'b1;
    step(1);
    chk("R1 status after reset", 32'(sts), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    irq_en = 1'b0;

    // Sweep: channel x polarity x rate x duration
    for (int ch = 0; ch < 3; ch++) begin
      for (int pl = 0; pl < 2; pl++) begin
        for (int rt = 0; rt < 8; rt++) begin
          for (int du = 0; du < 5; du++) begin
            int need;
            need = (du == 0) ? 1 : du;
            pin = '0;
            do_reset();
            pin[ch] = pl[0];
            wcfg(ch, pl[0], rt, du);
            step(3);
            pulse(rt);
            chk("R7 inactive level ignored", 32'(sts), 0);
            pin[ch] = ~pl[0];
            step(3);
            for (int k = 1; k < 8; k++) begin
              pulse((rt + k) % 8);
            end
            chk("R3 unselected ticks ignored", 32'(sts), 0);
            for (int k = 1; k <= need; k++) begin
              pulse(rt);
              if (du == 0) chk("R5 zero duration", 32'(sts), (k >= need) ? (1 << ch) : 0);
              else         chk("R4 duration count", 32'(sts), (k >= need) ? (1 << ch) : 0);
            end
          end
        end
      end
    end

    // R2: synchronizer latency, channel 0, duration 0, fastest rate
    pin = '0;
    do_reset();
    wcfg(0, 1'b0, int'(tampf_pkg::RATE_32K), 0);
    step(3);
    pin[0] = 1'b1;
    tick[0] = 1'b1;
    step(1);
    chk("R2 not seen at edge k", 32'(sts), 0);
    step(1);
    chk("R2 not seen at edge k+1", 32'(sts), 0);
    step(1);
    chk("R2 seen at edge k+2", 32'(sts), 1);
    tick = '0;

    // R9: sticky and clear
    pin[0] = 1'b0;
    step(3);
    chk("R9 status sticky", 32'(sts), 1);
    irq_en = 1'b0;
    step(1);
    chk("R10 irq gated off", 32'(irq), 0);
    irq_en = 1'b1;
    step(1);
    chk("R10 irq raised", 32'(irq), 1);
    sts_clr = 4'b0001;
    step(1);
    sts_clr = '0;
    chk("R9 clear by write one", 32'(sts), 0);
    chk("R10 irq drops with status", 32'(irq), 0);
    pin[0] = 1'b1;
    step(3);
    tick[0] = 1'b1;
    sts_clr = 4'b0001;
    step(1);
    tick = '0; sts_clr = '0;
    chk("R9 set wins over clear", 32'(sts), 1);

    // R6: run broken by an inactive tick, channel 1, duration 3, rate code 2
    pin = '0;
    do_reset();
    wcfg(1, 1'b0, 2, 3);
    pin[1] = 1'b1;
    step(3);
    pulse(2); pulse(2);
    chk("R6 two ticks short of three", 32'(sts), 0);
    pin[1] = 1'b0;
    step(3);
    pulse(2);
    pin[1] = 1'b1;
    step(3);
    pulse(2); pulse(2);
    chk("R6 count restarted after idle tick", 32'(sts), 0);
    pulse(2);
    chk("R6 third tick of new run", 32'(sts), 2);

    // R8: internal source
    pin = '0;
    do_reset();
    irq_en = 1'b1;
    int_src = 1'b1;
    step(1);
    int_src = 1'b0;
    chk("R8 internal sets bit 3", 32'(sts), 8);
    step(2);
    chk("R8 internal bit sticky", 32'(sts), 8);
    chk("R10 irq from internal", 32'(irq), 1);
    irq_en = 1'b0;

    // R11: lock freezes settings
    pin = '0;
    do_reset();
    wcfg(0, 1'b0, 0, 1);
    cfg_lock = 1'b1;
    step(1);
    cfg_lock = 1'b0;
    wcfg(0, 1'b1, 5, 7);
    pin[0] = 1'b1;
    step(3);
    pulse(0);
    chk("R11 write after lock ignored", 32'(sts), 1);
    pin = '0;
    do_reset();
    wcfg(0, 1'b1, 0, 0);
    pin[0] = 1'b0;
    step(3);
    pulse(0);
    chk("R11 reset releases lock", 32'(sts), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule